// File: doc/BRIEF.md
# Dependence-Aware Load Way-Access Controller

This block sits between the address stage of an in-order pipeline and a small four-way, set-associative L1 data array. For each load it decides whether all data ways must be read in the same cycle as the tag lookup, or whether the tags can be read first and a single data way read in the following cycle. The decision comes from a one-cycle-early check. The load's destination register is compared with both source register fields of the instruction directly behind it. If that instruction needs the loaded value, the load takes the fast, all-way (parallel) path so that no stall is added. If it does not, the extra cycle of the sequential path costs nothing, and only one data way is switched on.

The control is a two-state machine. In `ST_IDLE` the block accepts a load. The transition `IDLE->DATA` is taken when an accepted load has no dependence; otherwise the block stays in `IDLE`. `ST_DATA` is the one-cycle data phase of a sequential load. In that phase `busy` is high, only the matched way's data enable is driven, and new loads are refused. The transition `DATA->IDLE` is always taken after one cycle. The tag and data arrays are read-only in this block. They come out of reset with a fixed pattern, because filling them belongs to other logic. Exported counters let the surrounding logic or a bench see how many loads took each path and how many data-way reads were spent.

Top module: `way_access_ctrl`

## Requirements
- R1: During reset and right after it, `rsp_done`, `rsp_valid`, `busy`, every `tag_en` and `data_en` bit, and all three counters are zero.
- R2: A load needs the parallel path when `nxt_valid` is 1, `ld_rd` is not 0, and `ld_rd` equals `nxt_rs1` or `nxt_rs2`. Every other load takes the sequential path.
- R3: In the cycle a load is accepted, all `tag_en` bits are 1. A parallel load also drives all `data_en` bits to 1 in that cycle. A sequential load drives `data_en` to 0 in that cycle.
- R4: A parallel load completes one cycle after acceptance. In that cycle `rsp_done` is 1, `rsp_par` is 1, and `rsp_hit`, `rsp_way` and `rsp_data` carry the result.
- R5: In the cycle after a sequential load is accepted, `busy` is 1 and `data_en` equals the one-hot hit way. All other data ways stay at 0. `tag_en` is 0 in that cycle.
- R6: A sequential load completes two cycles after acceptance, with `rsp_done` at 1 and `rsp_par` at 0.
- R7: On a miss, `rsp_done` pulses with `rsp_hit` and `rsp_valid` at 0. A sequential miss enables no data way at all. `rsp_valid` is 1 exactly when `rsp_done` and `rsp_hit` are both 1.
- R8: `busy` lasts exactly one cycle. A load presented while `busy` is 1 is ignored: it produces no response, no enable and no counter change.
- R9: `cnt_par` and `cnt_seq` count accepted loads of each kind. `cnt_den` adds the number of `data_en` bits that are 1 in every cycle.
- R10: Address layout is bits [1:0] byte offset, bits [5:2] set, bits [11:6] tag. After reset, way w of set s holds tag `w*16+s` and word `0xCA000000 + w*256 + s`.
- R11: `rsp_way` is one-hot on a hit and zero on a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load request present |
| ld_addr | input | 12 | Load byte address |
| ld_rd | input | 5 | Load destination register |
| nxt_valid | input | 1 | Following instruction slot holds a valid instruction |
| nxt_rs1 | input | 5 | Following instruction's first source register |
| nxt_rs2 | input | 5 | Following instruction's second source register |
| busy | output | 1 | Sequential data phase in progress; loads refused |
| tag_en | output | 4 | Per-way tag array read enable |
| data_en | output | 4 | Per-way data array read enable |
| rsp_done | output | 1 | Access finished this cycle |
| rsp_hit | output | 1 | Finished access hit |
| rsp_valid | output | 1 | Load data valid |
| rsp_way | output | 4 | One-hot hit way of the finished access |
| rsp_data | output | 32 | Load data word |
| rsp_par | output | 1 | Finished access used the parallel path |
| cnt_par | output | 16 | Accepted parallel loads |
| cnt_seq | output | 16 | Accepted sequential loads |
| cnt_den | output | 16 | Accumulated data-way enables |

## Verification
The one-hot checks assume that the tags within a set are all different. The reset pattern guarantees this, and the bench never rewrites the arrays. The timing properties assume the requester treats `busy` as a refusal and does not rely on a load presented during `busy` being held over. The bench therefore deliberately offers loads while `busy` is high and expects them to disappear. Addresses come only from the 12-bit space of R10, and source and destination registers are drawn from a small range so that dependences, zero-register cases and invalid following slots all occur often.

// File: rtl/wayctl_pkg.sv
package wayctl_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_DATA = 1'b1
    } seq_state_e;

    // Reset content of a data word: fixed pattern keyed by way and set.
    function automatic logic [WORD_W-1:0] init_word(input int way, input int set);
        return 32'hCA00_0000 + WORD_W'(way * 256 + set);
    endfunction

endpackage

// File: rtl/dep_detect.sv
module dep_detect #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] ld_rd,
    input  logic             nxt_valid,
    input  logic [REG_W-1:0] nxt_rs1,
    input  logic [REG_W-1:0] nxt_rs2,
    output logic             dep
);
    logic rd_live;
    logic hit1;
    logic hit2;

    always_comb begin
        rd_live = (ld_rd != '0);
        hit1    = (ld_rd == nxt_rs1);
        hit2    = (ld_rd == nxt_rs2);
        dep     = nxt_valid && rd_live && (hit1 || hit2);
    end
endmodule

// File: rtl/tag_lookup.sv
module tag_lookup #(
    parameter int WAYS  = 4,
    parameter int SETS  = 16,
    parameter int TAG_W = 6,
    parameter int SET_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SET_W-1:0] set_idx,
    input  logic [TAG_W-1:0] tag_in,
    output logic [WAYS-1:0]  match
);
    logic [TAG_W-1:0] tags [WAYS][SETS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WAYS; w++) begin
                for (int s = 0; s < SETS; s++) begin
                    tags[w][s] <= TAG_W'(w * SETS + s);
                end
            end
        end
    end

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign match[g] = en && (tags[g][set_idx] == tag_in);
    end

    // R11: distinct tags per set give at most one matching way
    assert_match_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
endmodule

// File: rtl/data_bank.sv
module data_bank #(
    parameter int WAYS  = 4,
    parameter int SETS  = 16,
    parameter int SET_W = 4,
    parameter int W     = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WAYS-1:0]  en,
    input  logic [SET_W-1:0] set_idx,
    input  logic [WAYS-1:0]  sel,
    output logic [W-1:0]     word
);
    import wayctl_pkg::*;

    logic [W-1:0] mem [WAYS][SETS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WAYS; w++) begin
                for (int s = 0; s < SETS; s++) begin
                    mem[w][s] <= W'(init_word(w, s));
                end
            end
        end
    end

    always_comb begin
        word = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (en[w] && sel[w]) word = word | mem[w][set_idx];
        end
    end

    // R5: a partial enable pattern is never more than one way
    assert_partial_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en != '0 && en != '1) |-> $onehot(en));
endmodule

// File: rtl/way_access_ctrl.sv
module way_access_ctrl #(
    parameter int WAYS   = 4,
    parameter int SETS   = 16,
    parameter int ADDR_W = 12,
    parameter int REG_W  = 5,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [REG_W-1:0]  ld_rd,
    input  logic              nxt_valid,
    input  logic [REG_W-1:0]  nxt_rs1,
    input  logic [REG_W-1:0]  nxt_rs2,
    output logic              busy,
    output logic [WAYS-1:0]   tag_en,
    output logic [WAYS-1:0]   data_en,
    output logic              rsp_done,
    output logic              rsp_hit,
    output logic              rsp_valid,
    output logic [WAYS-1:0]   rsp_way,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_par,
    output logic [CNT_W-1:0]  cnt_par,
    output logic [CNT_W-1:0]  cnt_seq,
    output logic [CNT_W-1:0]  cnt_den
);
    import wayctl_pkg::*;

    localparam int OFF_W = 2;
    localparam int SET_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - SET_W - OFF_W;
    localparam int POP_W = $clog2(WAYS + 1);

    seq_state_e state, state_nx;

    logic             dep;
    logic             accept;
    logic             go_par;
    logic             go_seq;
    logic [SET_W-1:0] set_in;
    logic [TAG_W-1:0] tag_in;
    logic [SET_W-1:0] set_q;
    logic [WAYS-1:0]  way_q;
    logic [WAYS-1:0]  match;
    logic [SET_W-1:0] bank_set;
    logic [WAYS-1:0]  bank_sel;
    logic [DATA_W-1:0] bank_word;
    logic [POP_W-1:0] den_pop;

    assign set_in = ld_addr[OFF_W +: SET_W];
    assign tag_in = ld_addr[OFF_W + SET_W +: TAG_W];

    dep_detect #(.REG_W(REG_W)) u_dep (
        .ld_rd     (ld_rd),
        .nxt_valid (nxt_valid),
        .nxt_rs1   (nxt_rs1),
        .nxt_rs2   (nxt_rs2),
        .dep       (dep)
    );

    tag_lookup #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .SET_W(SET_W)) u_tag (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (accept),
        .set_idx (set_in),
        .tag_in  (tag_in),
        .match   (match)
    );

    data_bank #(.WAYS(WAYS), .SETS(SETS), .SET_W(SET_W), .W(DATA_W)) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (data_en),
        .set_idx (bank_set),
        .sel     (bank_sel),
        .word    (bank_word)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (go_seq) state_nx = ST_DATA;
            ST_DATA: state_nx = ST_IDLE;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        busy     = 1'b0;
        accept   = 1'b0;
        tag_en   = '0;
        data_en  = '0;
        bank_set = set_in;
        bank_sel = match;
        unique case (state)
            ST_IDLE: begin
                accept  = ld_valid;
                tag_en  = {WAYS{ld_valid}};
                data_en = {WAYS{ld_valid && dep}};
            end
            ST_DATA: begin
                busy     = 1'b1;
                data_en  = way_q;
                bank_set = set_q;
                bank_sel = way_q;
            end
        endcase
    end

    assign go_par = accept && dep;
    assign go_seq = accept && !dep;

    // Sequential-load context held across the data phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_q <= '0;
            way_q <= '0;
        end else if (go_seq) begin
            set_q <= set_in;
            way_q <= match;
        end
    end

    // Response register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_done <= 1'b0;
            rsp_hit  <= 1'b0;
            rsp_way  <= '0;
            rsp_data <= '0;
            rsp_par  <= 1'b0;
        end else begin
            rsp_done <= go_par || busy;
            if (go_par || busy) begin
                rsp_hit  <= busy ? (|way_q) : (|match);
                rsp_way  <= busy ? way_q : match;
                rsp_data <= bank_word;
                rsp_par  <= go_par;
            end
        end
    end

    assign rsp_valid = rsp_done && rsp_hit;

    always_comb begin
        den_pop = '0;
        for (int w = 0; w < WAYS; w++) den_pop = den_pop + POP_W'(data_en[w]);
    end

    // Activity counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_par <= '0;
            cnt_seq <= '0;
            cnt_den <= '0;
        end else begin
            cnt_par <= cnt_par + CNT_W'(go_par);
            cnt_seq <= cnt_seq + CNT_W'(go_seq);
            cnt_den <= cnt_den + CNT_W'(den_pop);
        end
    end

    // R4: a parallel load answers on the next cycle, flagged parallel
    assert_par_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
        go_par |=> (rsp_done && rsp_par));

    // R6: a sequential load is still pending one cycle later
    assert_seq_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        go_seq |=> (busy && !rsp_done));

    // R8: the data phase lasts one cycle and ends in a response
    assert_busy_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy && rsp_done && !rsp_par));

    // R7: a data phase with no enabled way finishes without data
    assert_miss_no_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && data_en == '0) |=> (rsp_done && !rsp_valid));

    // R9: load counters move only when a load is taken
    assert_cnt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> ($stable(cnt_par) && $stable(cnt_seq)));

    // R5: during the data phase the tag arrays are idle
    assert_tag_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (tag_en == '0 && $onehot0(data_en)));
endmodule

// File: tb/tb_way_access_ctrl.sv
module tb_way_access_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid = 1'b0;
    logic [11:0] ld_addr = '0;
    logic [4:0]  ld_rd = '0;
    logic        nxt_valid = 1'b0;
    logic [4:0]  nxt_rs1 = '0;
    logic [4:0]  nxt_rs2 = '0;
    logic        busy;
    logic [3:0]  tag_en;
    logic [3:0]  data_en;
    logic        rsp_done;
    logic        rsp_hit;
    logic        rsp_valid;
    logic [3:0]  rsp_way;
    logic [31:0] rsp_data;
    logic        rsp_par;
    logic [15:0] cnt_par;
    logic [15:0] cnt_seq;
    logic [15:0] cnt_den;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    way_access_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_rd(ld_rd),
        .nxt_valid(nxt_valid), .nxt_rs1(nxt_rs1), .nxt_rs2(nxt_rs2), .busy(busy),
        .tag_en(tag_en), .data_en(data_en), .rsp_done(rsp_done), .rsp_hit(rsp_hit),
        .rsp_valid(rsp_valid), .rsp_way(rsp_way), .rsp_data(rsp_data), .rsp_par(rsp_par),
        .cnt_par(cnt_par), .cnt_seq(cnt_seq), .cnt_den(cnt_den)
    );

    // Reference model state
    bit          m_busy = 0;
    bit          m_hit = 0;
    int          m_way = 0;
    int          m_set = 0;
    bit          e_done = 0;
    bit          e_hit = 0;
    logic [3:0]  e_way = '0;
    logic [31:0] e_data = '0;
    bit          e_par = 0;
    int          e_cpar = 0;
    int          e_cseq = 0;
    int          e_cden = 0;

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, compare, advance the model.
    task automatic step(input bit lv, input logic [11:0] a, input logic [4:0] rd,
                        input bit nv, input logic [4:0] r1, input logic [4:0] r2);
        bit         acc, dep, hit;
        int         set, tag, way, pop;
        logic [3:0] x_ten, x_den;
        @(negedge clk);
        ld_valid = lv; ld_addr = a; ld_rd = rd;
        nxt_valid = nv; nxt_rs1 = r1; nxt_rs2 = r2;
        #1;
        // R2 dependence rule
        dep = nv && (rd != 0) && (rd == r1 || rd == r2);
        acc = lv && !m_busy;
        // R10 layout and reset content
        set = int'(a[5:2]);
        tag = int'(a[11:6]);
        hit = ((tag % 16) == set);
        way = tag / 16;
        x_ten = acc ? 4'hF : 4'h0;
        if (m_busy) x_den = m_hit ? 4'(1 << m_way) : 4'h0;
        else        x_den = (acc && dep) ? 4'hF : 4'h0;
        chk("R3", "tag_en", 32'(tag_en), 32'(x_ten));
        chk(m_busy ? "R5" : "R3", "data_en", 32'(data_en), 32'(x_den));
        chk("R8", "busy", 32'(busy), 32'(m_busy));
        chk("R4", "rsp_done", 32'(rsp_done), 32'(e_done));
        chk("R7", "rsp_valid", 32'(rsp_valid), 32'(e_done && e_hit));
        if (e_done) begin
            chk("R7", "rsp_hit", 32'(rsp_hit), 32'(e_hit));
            chk("R11", "rsp_way", 32'(rsp_way), 32'(e_way));
            chk("R6", "rsp_par", 32'(rsp_par), 32'(e_par));
            if (e_hit) chk("R10", "rsp_data", rsp_data, e_data);
        end
        chk("R9", "cnt_par", 32'(cnt_par), 32'(e_cpar));
        chk("R9", "cnt_seq", 32'(cnt_seq), 32'(e_cseq));
        chk("R9", "cnt_den", 32'(cnt_den), 32'(e_cden));
        // advance model
        pop = 0;
        for (int i = 0; i < 4; i++) pop += int'(x_den[i]);
        e_cden = (e_cden + pop) % 65536;
        if (m_busy) begin
            e_done = 1; e_hit = m_hit; e_par = 0;
            e_way = m_hit ? 4'(1 << m_way) : 4'h0;
            e_data = 32'hCA00_0000 + 32'(m_way * 256 + m_set);
            m_busy = 0;
        end else if (acc && dep) begin
            e_done = 1; e_hit = hit; e_par = 1;
            e_way = hit ? 4'(1 << way) : 4'h0;
            e_data = 32'hCA00_0000 + 32'(way * 256 + set);
            e_cpar++;
        end else if (acc) begin
            e_done = 0;
            m_busy = 1; m_hit = hit; m_way = way; m_set = set;
            e_cseq++;
        end else begin
            e_done = 0;
        end
    endtask

    function automatic logic [11:0] hit_addr(input int way, input int set);
        return {2'(way), 4'(set), 4'(set), 2'b00};
    endfunction

    function automatic logic [11:0] miss_addr(input int way, input int set);
        return {2'(way), 4'(set) ^ 4'h9, 4'(set), 2'b01};
    endfunction

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        // R1 reset state
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "rsp_done", 32'(rsp_done), 0);
        chk("R1", "busy", 32'(busy), 0);
        chk("R1", "tag_en", 32'(tag_en), 0);
        chk("R1", "cnt_den", 32'(cnt_den), 0);
        @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, 0);
        // R2/R4 parallel hit via rs1, then via rs2 (back to back)
        step(1, hit_addr(2, 5), 5'd7, 1, 5'd7, 5'd3);
        step(1, hit_addr(0, 15), 5'd9, 1, 5'd1, 5'd9);
        step(0, 0, 0, 0, 0, 0);
        // R2 register zero never a dependence -> sequential (R5, R6)
        step(1, hit_addr(3, 1), 5'd0, 1, 5'd0, 5'd0);
        // R8 load offered while busy is dropped
        step(1, hit_addr(1, 2), 5'd4, 1, 5'd4, 5'd4);
        step(0, 0, 0, 0, 0, 0);
        // R2 invalid following slot -> sequential
        step(1, hit_addr(1, 9), 5'd6, 0, 5'd6, 5'd6);
        step(0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        // R7 sequential miss, then parallel miss
        step(1, miss_addr(2, 4), 5'd3, 1, 5'd1, 5'd2);
        step(0, 0, 0, 0, 0, 0);
        step(1, miss_addr(0, 0), 5'd3, 1, 5'd3, 5'd2);
        step(0, 0, 0, 0, 0, 0);
        // mixed stream
        r = 32'h1234_5678;
        for (int n = 0; n < 400; n++) begin
            r ^= r << 13; r ^= r >> 17; r ^= r << 5;
            step(r[17] | r[18],
                 r[6] ? hit_addr(int'(r[1:0]), int'(r[5:2])) : miss_addr(int'(r[1:0]), int'(r[5:2])),
                 5'(r[9:8]), r[16], 5'(r[13:12]), 5'(r[15:14]));
        end
        step(0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule